// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a fully associative table of 32 address translations. Each slot holds one key and two output halves. The key is a virtual page-pair number, a size mask and an 8-bit address-space tag. Each half describes one physical frame, so a single slot maps two neighbouring virtual pages to two unrelated physical frames. The lookup port is combinational. It takes a virtual address, a load/store flag and the current address-space tag, and in the same cycle it returns the physical address, a 3-bit cache attribute, a fault code and a multiple-match flag.

Slots are loaded or overwritten through an indexed write port, one slot per clock. Each slot's size mask sets its page size independently, from 4 KB up to 8 MB per half, which is 16 MB per slot. A per-half global flag can make a slot match under every address-space tag. Refill software, page-table walking and victim choice live outside the block: the block only reports that a lookup found nothing.

Top module: `xlat_pair_tlb`

## Requirements
- R1: After reset no slot is in use. Every lookup reports fault code 1 (miss) with lk_multi low, and lk_pa and lk_attr are zero.
- R2: When wr_en is high at a rising clock edge, slot wr_idx takes all the written fields. Lookups before that edge see the old contents of the slot, and lookups after it see the new contents.
- R3: A slot in use matches when lk_va[31:13] equals its stored page-pair number in every bit its mask does not ignore, and either its address-space tag equals lk_asid or the slot is global. All slots are compared in parallel, and the result appears in the same cycle.
- R4: The mask must have the form 2^k-1 for k from 0 to 11. Mask bit i drops virtual bit 13+i from the compare, so one slot covers 2^(13+k) bytes, at most 16 MB.
- R5: For a slot whose mask has k ones, virtual bit 12+k selects the half: 0 selects the even half and 1 selects the odd half.
- R6: A slot is global only when the global flags written for both halves are 1.
- R7: On a clean translation, lk_pa[11:0] equals lk_va[11:0]. Bit 12+i equals lk_va[12+i] for i<k and frame bit i for i>=k, and bits 31:12 above the mask take the selected half's frame number. lk_attr is that half's 3-bit attribute, passed through unchanged (3 means cacheable and 2 means uncached).
- R8: Fault code values: 0 means none, 1 means miss, 2 means invalid, 3 means write-protect. A miss is reported when no slot matches. On any fault, lk_pa and lk_attr are zero.
- R9: When exactly one slot matches and its selected half has valid = 0, the fault is 2. This holds for loads and stores alike.
- R10: A store to a valid half whose dirty (write-enable) bit is 0 gives fault 3. A load to the same half translates normally, because loads ignore the dirty bit.
- R11: When two or more slots match, lk_multi is 1, the fault code is 0, and lk_pa and lk_attr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one slot at this edge |
| wr_idx | input | 5 | Slot to write |
| wr_vpn2 | input | 19 | Page-pair number (virtual bits 31:13) |
| wr_mask | input | 11 | Size mask, 2^k-1 |
| wr_asid | input | 8 | Address-space tag of the slot |
| wr_even_pfn | input | 20 | Even half frame number |
| wr_even_attr | input | 3 | Even half cache attribute |
| wr_even_dirty | input | 1 | Even half write enable |
| wr_even_valid | input | 1 | Even half valid |
| wr_even_global | input | 1 | Even half global flag |
| wr_odd_pfn | input | 20 | Odd half frame number |
| wr_odd_attr | input | 3 | Odd half cache attribute |
| wr_odd_dirty | input | 1 | Odd half write enable |
| wr_odd_valid | input | 1 | Odd half valid |
| wr_odd_global | input | 1 | Odd half global flag |
| lk_va | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 for a store, 0 for a load |
| lk_asid | input | 8 | Current address-space tag |
| lk_pa | output | 32 | Physical address |
| lk_attr | output | 3 | Cache attribute of the chosen half |
| lk_exc | output | 2 | Fault code |
| lk_multi | output | 1 | More than one slot matched |

## Verification
The assertions check the following on every clocked cycle:
- A miss comes only with an empty hit vector.
- A write-protect fault comes only on a store.
- The multiple-match flag tracks the population count of the hit vector and suppresses any translation.
- A clean result keeps the byte offset of the address.
- A write lands in its slot on the next edge.
- Every written mask has the legal 2^k-1 form.

Other behaviour needs the bench's scenarios and its own model. These are the half chosen for each page size, the passing of masked bits into the physical address, the AND of the two global flags, and the order of precedence between the invalid and write-protect faults. They also include the exact edge at which an overwrite becomes visible.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int unsigned PG_SHIFT = 12;

   typedef enum logic [1:0] {
      XC_NONE    = 2'd0,
      XC_MISS    = 2'd1,
      XC_INVALID = 2'd2,
      XC_WPROT   = 2'd3
   } xlat_exc_e;
endpackage

// File: rtl/xlat_slot.sv
// One translation slot: key storage, per-half payload, parallel compare.
module xlat_slot #(
   parameter int unsigned VPN2_W = 19,
   parameter int unsigned MASK_W = 11,
   parameter int unsigned ASID_W = 8,
   parameter int unsigned HALF_W = 25,
   localparam int unsigned BUN_W = MASK_W + 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [VPN2_W-1:0] wr_vpn2,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_glob,
   input  logic [HALF_W-1:0] wr_even,
   input  logic [HALF_W-1:0] wr_odd,
   input  logic [VPN2_W-1:0] lk_vpn2,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              hit,
   output logic [BUN_W-1:0]  bundle
);
   logic              used_q;
   logic              glob_q;
   logic [VPN2_W-1:0] vpn2_q;
   logic [MASK_W-1:0] mask_q;
   logic [ASID_W-1:0] asid_q;
   logic [HALF_W-1:0] even_q;
   logic [HALF_W-1:0] odd_q;
   logic [VPN2_W-1:0] diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= 1'b0;
         glob_q <= 1'b0;
         vpn2_q <= '0;
         mask_q <= '0;
         asid_q <= '0;
         even_q <= '0;
         odd_q  <= '0;
      end else if (wr_sel) begin
         used_q <= 1'b1;
         glob_q <= wr_glob;
         vpn2_q <= wr_vpn2;
         mask_q <= wr_mask;
         asid_q <= wr_asid;
         even_q <= wr_even;
         odd_q  <= wr_odd;
      end
   end

   assign diff   = (vpn2_q ^ lk_vpn2) & ~VPN2_W'(mask_q);
   assign hit    = used_q && (diff == '0) && (glob_q || (asid_q == lk_asid));
   assign bundle = {mask_q, even_q, odd_q};

   // R2: a write is visible in the slot after the edge
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> (used_q && vpn2_q == $past(wr_vpn2) && asid_q == $past(wr_asid)));

   // R4: only masks of the form 2^k-1 are written
   a_r4_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |-> ((wr_mask & (wr_mask + 1'b1)) == '0));
endmodule

// File: rtl/xlat_select.sv
// OR-combines the payload of hitting slots and detects multiple hits.
module xlat_select #(
   parameter int unsigned N = 32,
   parameter int unsigned W = 61
) (
   input  logic [N-1:0]   hits,
   input  logic [N*W-1:0] data,
   output logic           any_hit,
   output logic           multi,
   output logic [W-1:0]   sel
);
   always_comb begin
      sel     = '0;
      any_hit = 1'b0;
      multi   = 1'b0;
      for (int i = 0; i < int'(N); i++) begin
         if (hits[i]) begin
            if (any_hit) multi = 1'b1;
            any_hit = 1'b1;
            sel = sel | data[i*W +: W];
         end
      end
   end
endmodule

// File: rtl/xlat_resolve.sv
// Picks the half, forms the physical address and the fault code.
module xlat_resolve
   import xlat_pkg::*;
#(
   parameter int unsigned MASK_W = 11,
   parameter int unsigned PFN_W  = 20,
   parameter int unsigned VA_W   = 32,
   localparam int unsigned HALF_W = PFN_W + 5,
   localparam int unsigned BUN_W  = MASK_W + 2 * HALF_W,
   localparam int unsigned PA_W   = PFN_W + PG_SHIFT
) (
   input  logic [VA_W-1:0]  va,
   input  logic             store,
   input  logic             any_hit,
   input  logic             multi,
   input  logic [BUN_W-1:0] bundle,
   output logic [PA_W-1:0]  pa,
   output logic [2:0]       attr,
   output xlat_exc_e        exc
);
   logic [MASK_W-1:0] mask;
   logic [HALF_W-1:0] even_h, odd_h, half;
   logic [MASK_W:0]   sel_oh;
   logic              pick_odd;
   logic [PFN_W-1:0]  pfn, pfn_eff, mext, vsub;
   logic [2:0]        h_attr;
   logic              h_dirty, h_valid, clean;

   assign {mask, even_h, odd_h} = bundle;
   assign sel_oh   = {1'b0, mask} + 1'b1;
   assign pick_odd = |(va[PG_SHIFT +: MASK_W+1] & sel_oh);
   assign half     = pick_odd ? odd_h : even_h;
   assign {pfn, h_attr, h_dirty, h_valid} = half;

   assign mext    = PFN_W'(mask);
   assign vsub    = PFN_W'(va[PG_SHIFT +: MASK_W]);
   assign pfn_eff = (pfn & ~mext) | (vsub & mext);

   always_comb begin
      if (multi)                 exc = XC_NONE;
      else if (!any_hit)         exc = XC_MISS;
      else if (!h_valid)         exc = XC_INVALID;
      else if (store && !h_dirty) exc = XC_WPROT;
      else                       exc = XC_NONE;
   end

   assign clean = any_hit && !multi && (exc == XC_NONE);
   assign pa    = clean ? {pfn_eff, va[PG_SHIFT-1:0]} : '0;
   assign attr  = clean ? h_attr : 3'd0;
endmodule

// File: rtl/xlat_pair_tlb.sv
module xlat_pair_tlb
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PFN_W   = 20,
   parameter int unsigned MASK_W  = 11,
   parameter int unsigned ASID_W  = 8,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned VPN2_W = VA_W - PG_SHIFT - 1,
   localparam int unsigned PA_W   = PFN_W + PG_SHIFT,
   localparam int unsigned HALF_W = PFN_W + 5,
   localparam int unsigned BUN_W  = MASK_W + 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN2_W-1:0] wr_vpn2,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PFN_W-1:0]  wr_even_pfn,
   input  logic [2:0]        wr_even_attr,
   input  logic              wr_even_dirty,
   input  logic              wr_even_valid,
   input  logic              wr_even_global,
   input  logic [PFN_W-1:0]  wr_odd_pfn,
   input  logic [2:0]        wr_odd_attr,
   input  logic              wr_odd_dirty,
   input  logic              wr_odd_valid,
   input  logic              wr_odd_global,
   input  logic [VA_W-1:0]   lk_va,
   input  logic              lk_store,
   input  logic [ASID_W-1:0] lk_asid,
   output logic [PA_W-1:0]   lk_pa,
   output logic [2:0]        lk_attr,
   output logic [1:0]        lk_exc,
   output logic              lk_multi
);
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (MASK_W + 1 > VPN2_W || MASK_W > PFN_W) begin : g_bad_mask
      $error("MASK_W exceeds the page-number widths");
   end

   logic [ENTRIES-1:0]       hits;
   logic [ENTRIES*BUN_W-1:0] bundles;
   logic [HALF_W-1:0]        even_in, odd_in;
   logic                     any_hit, multi;
   logic [BUN_W-1:0]         chosen;
   xlat_exc_e                exc;

   assign even_in = {wr_even_pfn, wr_even_attr, wr_even_dirty, wr_even_valid};
   assign odd_in  = {wr_odd_pfn,  wr_odd_attr,  wr_odd_dirty,  wr_odd_valid};

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      xlat_slot #(
         .VPN2_W(VPN2_W), .MASK_W(MASK_W), .ASID_W(ASID_W), .HALF_W(HALF_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_sel  (wr_en && (wr_idx == IDX_W'(i))),
         .wr_vpn2 (wr_vpn2),
         .wr_mask (wr_mask),
         .wr_asid (wr_asid),
         .wr_glob (wr_even_global & wr_odd_global),
         .wr_even (even_in),
         .wr_odd  (odd_in),
         .lk_vpn2 (lk_va[VA_W-1:PG_SHIFT+1]),
         .lk_asid (lk_asid),
         .hit     (hits[i]),
         .bundle  (bundles[i*BUN_W +: BUN_W])
      );
   end

   xlat_select #(.N(ENTRIES), .W(BUN_W)) u_sel (
      .hits    (hits),
      .data    (bundles),
      .any_hit (any_hit),
      .multi   (multi),
      .sel     (chosen)
   );

   xlat_resolve #(.MASK_W(MASK_W), .PFN_W(PFN_W), .VA_W(VA_W)) u_res (
      .va      (lk_va),
      .store   (lk_store),
      .any_hit (any_hit),
      .multi   (multi),
      .bundle  (chosen),
      .pa      (lk_pa),
      .attr    (lk_attr),
      .exc     (exc)
   );

   assign lk_exc   = exc;
   assign lk_multi = multi;

   // R8: a miss only when no slot hits
   a_r8_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_exc == XC_MISS) |-> (hits == '0));

   // R10: write-protect fault only on stores
   a_r10_wprot_store: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_exc == XC_WPROT) |-> lk_store);

   // R11: multiple-match flag tracks the hit population
   a_r11_multi_count: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi == ($countones(hits) > 1));

   // R11: a multiple match returns no translation
   a_r11_multi_blank: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi |-> (lk_pa == '0 && lk_attr == 3'd0 && lk_exc == XC_NONE));

   // R7: a clean hit keeps the byte offset
   a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot(hits) && lk_exc == XC_NONE) |-> (lk_pa[PG_SHIFT-1:0] == lk_va[PG_SHIFT-1:0]));
endmodule

// File: tb/xlat_pair_tlb_tb.sv
module xlat_pair_tlb_tb;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [18:0] wr_vpn2 = '0;
   logic [10:0] wr_mask = '0;
   logic [7:0]  wr_asid = '0;
   logic [19:0] wr_even_pfn = '0, wr_odd_pfn = '0;
   logic [2:0]  wr_even_attr = '0, wr_odd_attr = '0;
   logic        wr_even_dirty = 0, wr_even_valid = 0, wr_even_global = 0;
   logic        wr_odd_dirty = 0, wr_odd_valid = 0, wr_odd_global = 0;
   logic [31:0] lk_va = '0;
   logic        lk_store = 1'b0;
   logic [7:0]  lk_asid = '0;
   logic [31:0] lk_pa;
   logic [2:0]  lk_attr;
   logic [1:0]  lk_exc;
   logic        lk_multi;

   int n_run = 0;
   int n_fail = 0;

   // bench-side record of written slots
   logic        m_use [N];
   logic [18:0] m_vpn2 [N];
   logic [10:0] m_mask [N];
   logic [7:0]  m_asid [N];
   logic        m_glob [N];
   logic [19:0] m_pfn [N][2];
   logic [2:0]  m_attr [N][2];
   logic        m_d [N][2];
   logic        m_v [N][2];

   always #4 clk = ~clk;

   xlat_pair_tlb u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2),
      .wr_mask(wr_mask), .wr_asid(wr_asid),
      .wr_even_pfn(wr_even_pfn), .wr_even_attr(wr_even_attr), .wr_even_dirty(wr_even_dirty),
      .wr_even_valid(wr_even_valid), .wr_even_global(wr_even_global),
      .wr_odd_pfn(wr_odd_pfn), .wr_odd_attr(wr_odd_attr), .wr_odd_dirty(wr_odd_dirty),
      .wr_odd_valid(wr_odd_valid), .wr_odd_global(wr_odd_global),
      .lk_va(lk_va), .lk_store(lk_store), .lk_asid(lk_asid),
      .lk_pa(lk_pa), .lk_attr(lk_attr), .lk_exc(lk_exc), .lk_multi(lk_multi)
   );

   task automatic model(input logic [31:0] va, input logic st, input logic [7:0] asid,
                        output logic [31:0] pa, output logic [2:0] at,
                        output logic [1:0] ex, output logic mu);
      int nh = 0;
      int w = 0;
      pa = '0; at = '0; ex = 2'd0; mu = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (m_use[i] && (((m_vpn2[i] ^ va[31:13]) & ~{8'b0, m_mask[i]}) == 19'd0)
             && (m_glob[i] || m_asid[i] == asid)) begin
            nh++;
            w = i;
         end
      end
      if (nh > 1) mu = 1'b1;
      else if (nh == 0) ex = 2'd1;
      else begin
         int k = 0;
         int h;
         for (int b = 0; b < 11; b++) if (m_mask[w][b]) k++;
         h = va[12 + k] ? 1 : 0;
         if (!m_v[w][h]) ex = 2'd2;
         else if (st && !m_d[w][h]) ex = 2'd3;
         else begin
            pa = {m_pfn[w][h], 12'h000};
            for (int b = 0; b < k; b++) pa[12 + b] = va[12 + b];
            pa[11:0] = va[11:0];
            at = m_attr[w][h];
         end
      end
   endtask

   task automatic check(input string tag, input logic [31:0] va, input logic st,
                        input logic [7:0] asid);
      logic [31:0] e_pa;
      logic [2:0]  e_at;
      logic [1:0]  e_ex;
      logic        e_mu;
      lk_va = va; lk_store = st; lk_asid = asid;
      #1;
      model(va, st, asid, e_pa, e_at, e_ex, e_mu);
      n_run++;
      if (lk_pa !== e_pa || lk_attr !== e_at || lk_exc !== e_ex || lk_multi !== e_mu) begin
         n_fail++;
         $display("FAIL %s va=%h st=%0d asid=%h: got pa=%h attr=%0d exc=%0d multi=%0d, want pa=%h attr=%0d exc=%0d multi=%0d",
                  tag, va, st, asid, lk_pa, lk_attr, lk_exc, lk_multi, e_pa, e_at, e_ex, e_mu);
      end
   endtask

   task automatic drive_write(input int idx, input logic [18:0] vpn2, input logic [10:0] mask,
                              input logic [7:0] asid,
                              input logic [19:0] pe, input logic [2:0] ae, input logic de,
                              input logic ve, input logic ge,
                              input logic [19:0] po, input logic [2:0] ao, input logic d_o,
                              input logic vo, input logic go);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'(idx); wr_vpn2 = vpn2; wr_mask = mask; wr_asid = asid;
      wr_even_pfn = pe; wr_even_attr = ae; wr_even_dirty = de; wr_even_valid = ve; wr_even_global = ge;
      wr_odd_pfn = po; wr_odd_attr = ao; wr_odd_dirty = d_o; wr_odd_valid = vo; wr_odd_global = go;
   endtask

   task automatic commit_write;
      @(posedge clk);
      m_use[wr_idx] = 1'b1; m_vpn2[wr_idx] = wr_vpn2; m_mask[wr_idx] = wr_mask;
      m_asid[wr_idx] = wr_asid; m_glob[wr_idx] = wr_even_global & wr_odd_global;
      m_pfn[wr_idx][0] = wr_even_pfn; m_attr[wr_idx][0] = wr_even_attr;
      m_d[wr_idx][0] = wr_even_dirty; m_v[wr_idx][0] = wr_even_valid;
      m_pfn[wr_idx][1] = wr_odd_pfn; m_attr[wr_idx][1] = wr_odd_attr;
      m_d[wr_idx][1] = wr_odd_dirty; m_v[wr_idx][1] = wr_odd_valid;
      #1;
      wr_en = 1'b0;
   endtask

   task automatic put(input int idx, input logic [18:0] vpn2, input logic [10:0] mask,
                      input logic [7:0] asid,
                      input logic [19:0] pe, input logic [2:0] ae, input logic de,
                      input logic ve, input logic ge,
                      input logic [19:0] po, input logic [2:0] ao, input logic d_o,
                      input logic vo, input logic go);
      drive_write(idx, vpn2, mask, asid, pe, ae, de, ve, ge, po, ao, d_o, vo, go);
      commit_write();
   endtask

   initial begin : watchdog
      #(8 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < N; i++) m_use[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty after reset
      check("R1 reset miss", 32'h0000_0000, 1'b0, 8'h00);
      check("R1 reset miss", 32'h0100_1234, 1'b1, 8'h10);
      check("R1 reset miss", 32'hFFFF_F000, 1'b0, 8'hFF);

      // R3 R4 R5 R7: one slot per page size k
      for (int k = 0; k <= 11; k++) begin
         put(k, 19'((k + 1) << 11), 11'((1 << k) - 1), 8'(8'h10 + k),
             20'hA5A5A ^ 20'(k), 3'd3, 1'b1, 1'b1, 1'b0,
             20'h5A5A5 ^ 20'(k << 4), 3'd2, k[0], 1'b1, 1'b0);
      end
      for (int k = 0; k <= 11; k++) begin
         logic [31:0] base;
         base = 32'((k + 1) << 24);
         for (int j = 0; j < 8; j++) begin
            logic [31:0] off;
            off = (32'(j) * 32'h9E37_79B1) & ((32'h1 << (13 + k)) - 1);
            check("R4 R7 sized page", base | off, j[0], 8'(8'h10 + k));
         end
         check("R5 even half", base | 32'h123, 1'b0, 8'(8'h10 + k));
         check("R5 odd half", base | (32'h1 << (12 + k)) | 32'h456, 1'b0, 8'(8'h10 + k));
         check("R10 store odd", base | (32'h1 << (12 + k)), 1'b1, 8'(8'h10 + k));
         check("R3 tag mismatch", base | 32'h10, 1'b0, 8'(8'h90 + k));
         check("R3 above mask", base | (32'h1 << (13 + k)), 1'b0, 8'(8'h10 + k));
      end

      // R6: global only when both halves are global
      put(20, 19'(28 << 11), 11'h0, 8'h05, 20'h11111, 3'd3, 1'b1, 1'b1, 1'b1,
          20'h22222, 3'd2, 1'b1, 1'b1, 1'b1);
      put(21, 19'(29 << 11), 11'h0, 8'h06, 20'h33333, 3'd3, 1'b1, 1'b1, 1'b1,
          20'h44444, 3'd2, 1'b1, 1'b1, 1'b0);
      check("R6 global any tag", 32'h1C00_0ABC, 1'b0, 8'h77);
      check("R6 global any tag", 32'h1C00_1ABC, 1'b1, 8'hEE);
      check("R6 half global miss", 32'h1D00_0ABC, 1'b0, 8'h77);
      check("R6 half global own tag", 32'h1D00_1ABC, 1'b0, 8'h06);

      // R9 R10: invalid odd half, read-only even half
      put(22, 19'(30 << 11), 11'h3, 8'h07, 20'h55550, 3'd3, 1'b0, 1'b1, 1'b0,
          20'h66660, 3'd2, 1'b1, 1'b0, 1'b0);
      check("R9 invalid load", 32'h1E00_4000, 1'b0, 8'h07);
      check("R9 invalid store", 32'h1E00_4FFF, 1'b1, 8'h07);
      check("R10 wprot store", 32'h1E00_2010, 1'b1, 8'h07);
      check("R10 load ignores dirty", 32'h1E00_2010, 1'b0, 8'h07);

      // R11: duplicate of slot 0
      put(23, 19'(1 << 11), 11'h0, 8'h10, 20'hBEEF0, 3'd3, 1'b1, 1'b1, 1'b0,
          20'hBEEF1, 3'd3, 1'b1, 1'b1, 1'b0);
      check("R11 multi", 32'h0100_0123, 1'b0, 8'h10);
      check("R11 multi store", 32'h0100_1123, 1'b1, 8'h10);
      check("R11 single other tag", 32'h0100_0123, 1'b0, 8'h11);

      // R2: overwrite slot 23 away; old contents visible until the edge
      drive_write(23, 19'(31 << 11), 11'h0, 8'h10, 20'hCAFE0, 3'd2, 1'b1, 1'b1, 1'b0,
                  20'hCAFE1, 3'd3, 1'b1, 1'b1, 1'b0);
      check("R2 before edge", 32'h0100_0123, 1'b0, 8'h10);
      commit_write();
      check("R2 after edge old slot", 32'h0100_0123, 1'b0, 8'h10);
      check("R2 after edge new slot", 32'h1F00_1777, 1'b0, 8'h10);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule